// File: doc/BRIEF.md
# Serial SAR Converter Readout Master

This block is the host side of a three-wire link to a successive-approximation converter. The converter has a chip-select input, a data clock input and a serial data output. When a start request arrives, the block lowers chip select and produces a data clock from the system clock. It lets the sampling interval and the leading null bit pass, then collects the conversion result most significant bit first. The converter changes its data line after each falling clock edge, and the block captures that line at the point of the following rising edge.

A conversion can be cut short in two ways. The first is a programmed bit count. The second is a window mode: the block stops as soon as the bits received so far prove that the sample is above an upper limit or below a lower limit. In every case the block returns the result left-justified, the number of bits received and an out-of-window flag, all marked by a one-cycle valid pulse. Chip select then stays high for a guard interval before the next conversion can begin.

The controller has five states. IDLE waits for a start request and moves to SETUP when one arrives. SETUP holds chip select low with the clock low for one half period, then moves to HIGH. HIGH drives the data clock high for one half period, then moves to LOW. LOW drives the clock low for one half period. When that half period ends, LOW goes back to HIGH, unless the bit just captured is the final one, in which case it goes to GAP. GAP keeps chip select high for the guard interval, then returns to IDLE.

Top module: `sar_serial_reader`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, and busy_o, done_o, result_o, nbits_o and oow_o are all 0.
- R2: A start request in IDLE drives cs_n_o to 0 on the next cycle. sclk_o stays low for HALF_DIV system clocks before its first rise. Every high phase and every low phase of sclk_o lasts HALF_DIV system clocks.
- R3: Rising edges 1 to 3 carry no data: the first two cover sampling and the third is the null bit. Data bit k (k = 1..12, MSB first) is captured at the point of rising edge k+3. The edge for the final bit is not emitted, so a conversion of n bits shows exactly n+2 rising edges on sclk_o.
- R4: stop_bits_i is sampled when the conversion starts. A value of 1 to 12 ends the conversion after that many data bits, and 0 or any value above 12 means 12. nbits_o always lies between 1 and 12.
- R5: result_o holds the received bits left-justified: bit 11 is the first bit received, and every bit that was not received reads 0. nbits_o gives the number of bits received.
- R6: When win_en_i is 1 at the start, the block checks the prefix after every bit. It ends the conversion with oow_o = 1 as soon as the prefix filled with zeros is above win_hi_i, or the prefix filled with ones is below win_lo_i. In every other case oow_o is 0. Limits are inclusive.
- R7: done_o is high for exactly one system clock per conversion, in the cycle after the final bit is captured, with cs_n_o already 1. result_o, nbits_o and oow_o hold their values until the next done_o.
- R8: A start request while busy_o is 1 has no effect. This includes requests during the guard interval and requests with a new stop_bits_i value.
- R9: Between two conversions, cs_n_o stays high for at least CS_GAP+1 system clocks. With start held high, it stays high for exactly that long.
- R10: sclk_o is never high while cs_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, accepted in IDLE |
| stop_bits_i | input | 4 | Number of data bits to collect (0 or >12 means 12) |
| win_en_i | input | 1 | Enables early abort on out-of-window prefix |
| win_lo_i | input | 12 | Lower window limit, inclusive |
| win_hi_i | input | 12 | Upper window limit, inclusive |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Generated data clock |
| sdata_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | High whenever the controller is not in IDLE |
| done_o | output | 1 | One-cycle valid pulse for the outputs below |
| result_o | output | 12 | Left-justified result, unreceived bits zero |
| nbits_o | output | 4 | Number of data bits received |
| oow_o | output | 1 | Sample proven outside the window |

## Verification
Embedded assertions check these rules on every cycle: the minimum high and low clock phase lengths, the minimum chip-select guard time, that done is a single-cycle pulse issued with chip select high, that the result has zero bits below the received count, that the count stays in range, and that the out-of-window flag stays clear when window mode is off. The bench's scenarios are needed to show the rest. Those scenarios cover MSB-first assembly against a modelled converter that emits its null bit, the stop counts including the out-of-range values, abort on both the upper and lower limit including an exact-boundary window, the number of clock edges per conversion, and start requests that are ignored while busy.

// File: rtl/srd_pkg.sv
package srd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } srd_state_e;

    // rising edges before the first data bit: two acquisition edges plus the null bit
    localparam int LEAD_EDGES = 3;
endpackage

// File: rtl/srd_half_timer.sv
module srd_half_timer #(
    parameter int HALF_DIV = 8,
    localparam int CW = $clog2(HALF_DIV + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(HALF_DIV - 1)); // R2
endmodule

// File: rtl/srd_window_judge.sv
module srd_window_judge #(
    parameter int DATA_W = 12,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] prefix_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [DATA_W-1:0] hi_i,
    output logic              outside_o
);
    localparam logic [DATA_W-1:0] ALL1 = '1;

    logic [DATA_W-1:0] fill;
    logic [DATA_W-1:0] max_done;

    always_comb begin
        fill      = ALL1 >> count_i;
        max_done  = prefix_i | fill;
        outside_o = (prefix_i > hi_i) || (max_done < lo_i);
    end
endmodule

// File: rtl/sar_serial_reader.sv
module sar_serial_reader
    import srd_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int HALF_DIV = 8,
    parameter int CS_GAP   = 4,
    localparam int CNT_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  stop_bits_i,
    input  logic              win_en_i,
    input  logic [DATA_W-1:0] win_lo_i,
    input  logic [DATA_W-1:0] win_hi_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    input  logic              sdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic [CNT_W-1:0]  nbits_o,
    output logic              oow_o
);
    localparam int LW = $clog2(LEAD_EDGES + 1);
    localparam int GW = $clog2(CS_GAP + 1);
    localparam logic [DATA_W-1:0] ALL1 = '1;

    srd_state_e        state_q, state_d;
    logic              tick, timed, rise_ev, data_ev, last, abort, outside, accept;
    logic [LW-1:0]     lead_q;
    logic [CNT_W-1:0]  nb_q, nb_nx, stop_q, stop_eff;
    logic [DATA_W-1:0] acc_q, acc_nx, lo_q, hi_q;
    logic              wen_q;
    logic [GW-1:0]     gap_q;

    assign timed   = (state_q == ST_SETUP) || (state_q == ST_HIGH) || (state_q == ST_LOW);
    assign accept  = (state_q == ST_IDLE) && start_i;
    assign rise_ev = tick && ((state_q == ST_SETUP) || (state_q == ST_LOW));
    assign data_ev = rise_ev && (lead_q == LW'(LEAD_EDGES));
    assign nb_nx   = nb_q + CNT_W'(1);
    assign acc_nx  = acc_q | (DATA_W'(sdata_i) << (DATA_W - 1 - int'(nb_q)));
    assign abort   = wen_q && outside;
    assign last    = data_ev && ((nb_nx == stop_q) || abort);
    assign stop_eff = ((stop_bits_i == '0) || (stop_bits_i > CNT_W'(DATA_W)))
                      ? CNT_W'(DATA_W) : stop_bits_i;

    srd_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (timed),
        .tick_o (tick)
    );

    srd_window_judge #(.DATA_W(DATA_W)) u_judge (
        .prefix_i  (acc_nx),
        .count_i   (nb_nx),
        .lo_i      (lo_q),
        .hi_i      (hi_q),
        .outside_o (outside)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SETUP;
            ST_SETUP: if (tick)    state_d = ST_HIGH;
            ST_HIGH:  if (tick)    state_d = ST_LOW;
            ST_LOW:   if (tick)    state_d = last ? ST_GAP : ST_HIGH;
            ST_GAP:   if (gap_q == GW'(CS_GAP - 1)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_q   <= '0;
            nb_q     <= '0;
            acc_q    <= '0;
            stop_q   <= CNT_W'(DATA_W);
            wen_q    <= 1'b0;
            lo_q     <= '0;
            hi_q     <= '0;
            gap_q    <= '0;
            result_o <= '0;
            nbits_o  <= '0;
            oow_o    <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= last;
            gap_q  <= (state_q == ST_GAP) ? gap_q + GW'(1) : '0;
            if (accept) begin
                lead_q <= '0;
                nb_q   <= '0;
                acc_q  <= '0;
                stop_q <= stop_eff;
                wen_q  <= win_en_i;
                lo_q   <= win_lo_i;
                hi_q   <= win_hi_i;
            end else if (data_ev) begin
                acc_q <= acc_nx;
                nb_q  <= nb_nx;
            end else if (rise_ev) begin
                lead_q <= lead_q + LW'(1);
            end
            if (last) begin
                result_o <= acc_nx;
                nbits_o  <= nb_nx;
                oow_o    <= abort;
            end
        end
    end

    // pin outputs
    always_comb begin
        cs_n_o = !timed;
        sclk_o = (state_q == ST_HIGH);
        busy_o = (state_q != ST_IDLE);
    end

    // checker counters for phase and guard lengths
    logic [31:0] hi_run, lo_run, csh_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run  <= '0;
            lo_run  <= '0;
            csh_run <= 32'(CS_GAP + 1);
        end else begin
            hi_run  <= sclk_o ? ((hi_run == '1) ? hi_run : hi_run + 32'd1) : '0;
            lo_run  <= (!sclk_o && !cs_n_o) ? ((lo_run == '1) ? lo_run : lo_run + 32'd1) : '0;
            csh_run <= cs_n_o ? ((csh_run == '1) ? csh_run : csh_run + 32'd1) : '0;
        end
    end

    AST_SCLK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_run >= 32'(HALF_DIV))); // R2
    AST_SCLK_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (lo_run >= 32'(HALF_DIV))); // R2
    AST_CS_GUARD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (csh_run >= 32'(CS_GAP + 1))); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !sclk_o)); // R7
    AST_LEFT_JUST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((result_o & (ALL1 >> nbits_o)) == '0)); // R5
    AST_NBITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((nbits_o >= CNT_W'(1)) && (nbits_o <= CNT_W'(DATA_W)))); // R4
    AST_OOW_ONLY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !wen_q) |-> !oow_o); // R6
    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $past(!cs_n_o)); // R10
endmodule

// File: tb/sar_serial_reader_tb.sv
module sar_serial_reader_tb;
    localparam int HALF_DIV = 8;
    localparam int CS_GAP   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  stop_bits_i = 4'd12;
    logic        win_en_i = 1'b0;
    logic [11:0] win_lo_i = '0, win_hi_i = '0;
    logic        cs_n_o, sclk_o, busy_o, done_o, oow_o;
    logic [11:0] result_o;
    logic [3:0]  nbits_o;
    logic        sdata = 1'b0;

    int compared = 0, mismatched = 0;

    always #10 clk = ~clk;

    sar_serial_reader #(.DATA_W(12), .HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_bits_i(stop_bits_i),
        .win_en_i(win_en_i), .win_lo_i(win_lo_i), .win_hi_i(win_hi_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdata_i(sdata), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o), .nbits_o(nbits_o), .oow_o(oow_o)
    );

    // converter model: null bit after the 2nd falling edge, MSB after the 3rd
    logic [11:0] adc_code = '0;
    int fcnt = 0;
    always @(negedge sclk_o or posedge cs_n_o) begin
        if (cs_n_o) begin
            fcnt = 0;
            sdata = 1'b0;
        end else begin
            fcnt = fcnt + 1;
            if (fcnt >= 3 && fcnt <= 14) sdata = adc_code[14 - fcnt];
            else sdata = 1'b0;
        end
    end

    int rises = 0;
    always @(posedge sclk_o) rises = rises + 1;

    int sclk_bad = 0;
    always @(negedge clk) if (sclk_o === 1'b1 && cs_n_o === 1'b1) sclk_bad = sclk_bad + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    logic [11:0] got_res;
    logic [3:0]  got_n;
    logic        got_oow;
    int          got_rises;
    bit          got_done;

    task automatic wait_done();
        got_done = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done_o) begin
                got_done = 1'b1;
                break;
            end
        end
        got_res = result_o;
        got_n   = nbits_o;
        got_oow = oow_o;
    endtask

    task automatic run_conv(input logic [11:0] code, input logic [3:0] stop,
                            input logic wen, input logic [11:0] lo, input logic [11:0] hi);
        int r0;
        @(negedge clk);
        adc_code = code;
        stop_bits_i = stop;
        win_en_i = wen;
        win_lo_i = lo;
        win_hi_i = hi;
        r0 = rises;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        got_rises = rises - r0;
    endtask

    typedef struct packed {
        logic [11:0] code;
        logic [3:0]  stop;
        logic        wen;
        logic [11:0] lo;
        logic [11:0] hi;
        logic [11:0] e_res;
        logic [3:0]  e_n;
        logic        e_oow;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{12'hA5C, 4'd12, 1'b0, 12'h000, 12'hFFF, 12'hA5C, 4'd12, 1'b0},
        '{12'h800, 4'd12, 1'b0, 12'h000, 12'hFFF, 12'h800, 4'd12, 1'b0},
        '{12'hFFF, 4'd8,  1'b0, 12'h000, 12'hFFF, 12'hFF0, 4'd8,  1'b0},
        '{12'h123, 4'd0,  1'b0, 12'h000, 12'hFFF, 12'h123, 4'd12, 1'b0},
        '{12'h3C7, 4'd1,  1'b0, 12'h000, 12'hFFF, 12'h000, 4'd1,  1'b0},
        '{12'hF00, 4'd12, 1'b1, 12'h100, 12'h7FF, 12'h800, 4'd1,  1'b1},
        '{12'h050, 4'd12, 1'b1, 12'h400, 12'hFFF, 12'h000, 4'd2,  1'b1},
        '{12'h5A5, 4'd12, 1'b1, 12'h100, 12'h900, 12'h5A5, 4'd12, 1'b0},
        '{12'h5A5, 4'd4,  1'b1, 12'h100, 12'h900, 12'h500, 4'd4,  1'b0},
        '{12'h0F1, 4'd15, 1'b0, 12'h000, 12'hFFF, 12'h0F1, 4'd12, 1'b0},
        '{12'hC80, 4'd12, 1'b1, 12'h000, 12'hA00, 12'hC00, 4'd2,  1'b1},
        '{12'h800, 4'd12, 1'b1, 12'h800, 12'h800, 12'h800, 4'd12, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int lo_cnt, hi_cnt, gap_cnt, cs_low_seen, extra_done;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o === 1'b1 && sclk_o === 1'b0, "R1 pins", {cs_n_o, sclk_o}, 2'b10);
        chk(busy_o === 1'b0 && done_o === 1'b0 && oow_o === 1'b0, "R1 flags",
            {busy_o, done_o, oow_o}, 0);
        chk(result_o === 12'h0 && nbits_o === 4'h0, "R1 result", {result_o, nbits_o}, 0);

        // vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            run_conv(VECS[v].code, VECS[v].stop, VECS[v].wen, VECS[v].lo, VECS[v].hi);
            chk(got_done, "R7 done seen", got_done, 1);
            chk(got_res === VECS[v].e_res, "R5 result", got_res, VECS[v].e_res);
            chk(got_n === VECS[v].e_n, "R4 nbits", got_n, VECS[v].e_n);
            chk(got_oow === VECS[v].e_oow, "R6 oow", got_oow, VECS[v].e_oow);
            chk(got_rises == int'(VECS[v].e_n) + 2, "R3 edge count", got_rises, VECS[v].e_n + 2);
            chk(cs_n_o === 1'b1, "R7 cs high at done", cs_n_o, 1);
            @(negedge clk);
            chk(done_o === 1'b0, "R7 single pulse", done_o, 0);
            chk(result_o === VECS[v].e_res, "R7 result held", result_o, VECS[v].e_res);
            repeat (CS_GAP + 2) @(negedge clk);
        end

        // R2 phase lengths
        @(negedge clk);
        adc_code = 12'h3A1; stop_bits_i = 4'd12; win_en_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(cs_n_o === 1'b0, "R2 cs falls next cycle", cs_n_o, 0);
        lo_cnt = 0;
        while (sclk_o === 1'b0 && lo_cnt < 1000) begin lo_cnt++; @(negedge clk); end
        chk(lo_cnt == HALF_DIV, "R2 setup low length", lo_cnt, HALF_DIV);
        hi_cnt = 0;
        while (sclk_o === 1'b1 && hi_cnt < 1000) begin hi_cnt++; @(negedge clk); end
        chk(hi_cnt == HALF_DIV, "R2 high length", hi_cnt, HALF_DIV);
        lo_cnt = 0;
        while (sclk_o === 1'b0 && lo_cnt < 1000) begin lo_cnt++; @(negedge clk); end
        chk(lo_cnt == HALF_DIV, "R2 low length", lo_cnt, HALF_DIV);
        wait_done();
        chk(got_res === 12'h3A1, "R3 msb first", got_res, 12'h3A1);

        // R8 start while busy (new stop count) and during guard is ignored
        repeat (CS_GAP + 2) @(negedge clk);
        adc_code = 12'h6B2; stop_bits_i = 4'd12;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        stop_bits_i = 4'd1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk(got_n === 4'd12 && got_res === 12'h6B2, "R8 busy start ignored, R4 latched",
            {got_n, got_res}, {4'd12, 12'h6B2});
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cs_low_seen = 0;
        extra_done = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (cs_n_o !== 1'b1) cs_low_seen++;
            if (done_o) extra_done++;
        end
        chk(cs_low_seen == 0 && extra_done == 0, "R8 guard start ignored",
            cs_low_seen + extra_done, 0);
        chk(busy_o === 1'b0, "R8 idle after", busy_o, 0);

        // R9 back-to-back guard length with start held
        adc_code = 12'h0AA; stop_bits_i = 4'd3;
        start_i = 1'b1;
        wait_done();
        gap_cnt = 0;
        while (cs_n_o === 1'b1 && gap_cnt < 1000) begin gap_cnt++; @(negedge clk); end
        start_i = 1'b0;
        chk(gap_cnt == CS_GAP + 1, "R9 guard length", gap_cnt, CS_GAP + 1);
        wait_done();
        chk(got_res === 12'h000 && got_n === 4'd3, "R4 short second conv",
            {got_n, got_res}, {4'd3, 12'h000});
        repeat (20) @(negedge clk);

        chk(sclk_bad == 0, "R10 sclk under cs", sclk_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule